// File: doc/BRIEF.md
# Programmable CRT Raster Timing Generator

This block produces the raster timing for a cathode-ray display from a small set of write-only timing registers. A 3-bit dot counter divides the dot clock into 8-dot characters; a character counter sweeps across each line and a line counter sweeps down each frame. Horizontal and vertical sync pulses, a display-enable window and a one-dot raster-line interrupt are decoded from these counters.

Software programs the timing through a simple write port. Each write lands in a shadow register. The whole shadow set is copied into the working set on the last dot of a frame, so a change never tears a frame in progress. The register values carry fixed offsets. Totals and sync ends are stored minus one. Horizontal display start and end are stored minus five. Vertical display start is stored minus one. The interrupt line value is written as vertical start plus one plus the wanted active line.

Top module: `crt_timing_gen`

## Requirements
- R1: `dot_col[2:0]` counts 0..7 on every clock. `dot_col[H_W+2:3]` (the character count) steps when the dot count is 7. After the character equal to the horizontal total it returns to 0.
- R2: Bit 0 of the horizontal total is forced to 1 on every write. A written value of 6 therefore gives 8 characters per line.
- R3: `line` steps by one at the end of every line. After the line equal to the vertical total it returns to 0.
- R4: `hsync_n` is low while the character count is at most the horizontal sync end value, and high otherwise.
- R5: `vsync_n` is low while `line` is at most the vertical sync end value, and high otherwise.
- R6: Horizontally, `de` can be high only for character counts from horizontal start + 5 through horizontal end + 5, inclusive.
- R7: Vertically, `de` can be high only for lines greater than vertical start and at most vertical end. Inside both windows `de` is high.
- R8: `raster_irq` is high for exactly one clock, at dot 0 of character 0 of the line equal to the interrupt value. Writing vertical start + 1 + n makes it fire on active line n.
- R9: Writes use these `wr_sel` codes: 0 horizontal total, 1 vertical total, 2 horizontal sync end, 3 vertical sync end, 4 horizontal start, 5 horizontal end, 6 vertical start, 7 vertical end, 8 interrupt line. Codes 9..15 are ignored. A write changes behaviour only from the frame that follows the current one.
- R10: While `rst_n` is low, all counters are 0 and the timing values are the `INIT_*` parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select code |
| wr_data | input | V_W | Write value; horizontal registers take the low H_W bits |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Display enable |
| dot_col | output | H_W+3 | Current column: character count above, dot count in the low 3 bits |
| line | output | V_W | Current line |
| raster_irq | output | 1 | One-clock raster-line interrupt |

## Verification
Every output is decoded from the counters and the working register set. A counter that slips or wraps at the wrong value therefore moves `dot_col` or `line` on the very next clock. It also shifts the sync and enable edges for the rest of the frame. A shadow set loaded at the wrong moment shows up differently: the frame boundary and the window edges move at once, by whole lines or whole characters. The bench predicts every output on every clock across three register sets, switched at frame boundaries. A fault of either kind therefore shows up within one line of where it starts.

// File: rtl/crt_timing_gen.sv
module crt_timing_gen #(
  parameter int H_W          = 8,
  parameter int V_W          = 10,
  parameter int INIT_HTOTAL  = 99,
  parameter int INIT_VTOTAL  = 524,
  parameter int INIT_HSYNC   = 11,
  parameter int INIT_VSYNC   = 1,
  parameter int INIT_HSTART  = 8,
  parameter int INIT_HEND    = 88,
  parameter int INIT_VSTART  = 34,
  parameter int INIT_VEND    = 514,
  parameter int INIT_IRQ     = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [3:0]     wr_sel,
  input  logic [V_W-1:0] wr_data,
  output logic           hsync_n,
  output logic           vsync_n,
  output logic           de,
  output logic [H_W+2:0] dot_col,
  output logic [V_W-1:0] line,
  output logic           raster_irq
);

  localparam int HX = H_W + 1;
  localparam logic [HX-1:0] HOFS = HX'(5);
  localparam logic [H_W-1:0] HT0 = H_W'(INIT_HTOTAL) | H_W'(1);

  logic [H_W-1:0] s_ht, s_hs, s_ha, s_he, a_ht, a_hs, a_ha, a_he;
  logic [V_W-1:0] s_vt, s_vs, s_va, s_ve, s_irq, a_vt, a_vs, a_va, a_ve, a_irq;

  logic [2:0]     dot_q;
  logic [H_W-1:0] chr_q;
  logic [V_W-1:0] ln_q;

  wire char_end  = dot_q == 3'd7;
  wire line_end  = char_end && (chr_q == a_ht);
  wire frame_end = line_end && (ln_q == a_vt);
  wire [H_W-1:0] wr_h = wr_data[H_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_ht <= HT0;               s_vt <= V_W'(INIT_VTOTAL);
      s_hs <= H_W'(INIT_HSYNC);  s_vs <= V_W'(INIT_VSYNC);
      s_ha <= H_W'(INIT_HSTART); s_he <= H_W'(INIT_HEND);
      s_va <= V_W'(INIT_VSTART); s_ve <= V_W'(INIT_VEND);
      s_irq <= V_W'(INIT_IRQ);
    end else if (wr_en) begin
      case (wr_sel)
        4'd0: s_ht  <= wr_h | H_W'(1);
        4'd1: s_vt  <= wr_data;
        4'd2: s_hs  <= wr_h;
        4'd3: s_vs  <= wr_data;
        4'd4: s_ha  <= wr_h;
        4'd5: s_he  <= wr_h;
        4'd6: s_va  <= wr_data;
        4'd7: s_ve  <= wr_data;
        4'd8: s_irq <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_ht <= HT0;               a_vt <= V_W'(INIT_VTOTAL);
      a_hs <= H_W'(INIT_HSYNC);  a_vs <= V_W'(INIT_VSYNC);
      a_ha <= H_W'(INIT_HSTART); a_he <= H_W'(INIT_HEND);
      a_va <= V_W'(INIT_VSTART); a_ve <= V_W'(INIT_VEND);
      a_irq <= V_W'(INIT_IRQ);
    end else if (frame_end) begin
      a_ht <= s_ht; a_vt <= s_vt; a_hs <= s_hs; a_vs <= s_vs;
      a_ha <= s_ha; a_he <= s_he; a_va <= s_va; a_ve <= s_ve;
      a_irq <= s_irq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot_q <= '0;
      chr_q <= '0;
      ln_q  <= '0;
    end else begin
      dot_q <= dot_q + 3'd1;
      if (char_end) chr_q <= line_end ? '0 : chr_q + H_W'(1);
      if (line_end) ln_q  <= frame_end ? '0 : ln_q + V_W'(1);
    end
  end

  wire h_win = ({1'b0, chr_q} >= ({1'b0, a_ha} + HOFS)) &&
               ({1'b0, chr_q} <= ({1'b0, a_he} + HOFS));
  wire v_win = (ln_q > a_va) && (ln_q <= a_ve);

  assign hsync_n    = !(chr_q <= a_hs);
  assign vsync_n    = !(ln_q <= a_vs);
  assign de         = h_win && v_win;
  assign dot_col    = {chr_q, dot_q};
  assign line       = ln_q;
  assign raster_irq = (ln_q == a_irq) && (chr_q == '0) && (dot_q == 3'd0);

  AST_DOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_col[2:0] != 3'd7) |=> (dot_col[2:0] == $past(dot_col[2:0]) + 3'd1)); // R1
  AST_CHAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_col[2:0] != 3'd7) |=> $stable(dot_col[H_W+2:3])); // R1
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_col[2:0] != 3'd7) |=> $stable(line)); // R3
  AST_HTOT_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    a_ht[0] && s_ht[0]); // R2
  AST_HSYNC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_col[H_W+2:3] == '0) |-> !hsync_n); // R4
  AST_VSYNC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (line == '0) |-> !vsync_n); // R5
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    raster_irq |=> !raster_irq); // R8
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable({a_ht, a_vt, a_hs, a_vs, a_ha, a_he, a_va, a_ve, a_irq})); // R9

endmodule

// File: tb/crt_timing_gen_tb_top.sv
module crt_timing_gen_tb_top;
  localparam int H_W = 8;
  localparam int V_W = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [3:0]     wr_sel = '0;
  logic [V_W-1:0] wr_data = '0;
  logic           hsync_n, vsync_n, de, raster_irq;
  logic [H_W+2:0] dot_col;
  logic [V_W-1:0] line;

  always #10 clk = ~clk;

  crt_timing_gen #(
    .H_W(H_W), .V_W(V_W),
    .INIT_HTOTAL(11), .INIT_VTOTAL(11), .INIT_HSYNC(1), .INIT_VSYNC(1),
    .INIT_HSTART(0), .INIT_HEND(4), .INIT_VSTART(2), .INIT_VEND(9), .INIT_IRQ(5)
  ) dut_i (.*);

  // index: 0 htot 1 vtot 2 hsync 3 vsync 4 hstart 5 hend 6 vstart 7 vend 8 irq
  int cur[9]  = '{11, 11, 1, 1, 0, 4, 2, 9, 5};
  int pend[9] = '{11, 11, 1, 1, 0, 4, 2, 9, 5};
  int c = 0;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  function automatic int frame_len();
    return (cur[0] + 1) * 8 * (cur[1] + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s c=%0d actual=%0d expected=%0d", tag, c, act, exp);
    end
  endtask

  task automatic check_all();
    int p   = (cur[0] + 1) * 8;
    int dt  = c % 8;
    int ch  = (c / 8) % (cur[0] + 1);
    int ln  = c / p;
    int col = ch * 8 + dt;
    bit hs  = !(ch <= cur[2]);
    bit vs  = !(ln <= cur[3]);
    bit dx  = (ch >= cur[4] + 5) && (ch <= cur[5] + 5) && (ln > cur[6]) && (ln <= cur[7]);
    bit iq  = (ln == cur[8]) && (c % p == 0);
    chk(int'(dot_col) == col, "R1 dot_col", int'(dot_col), col);
    chk(int'(line) == ln, "R3 line", int'(line), ln);
    chk(hsync_n == hs, "R4 hsync_n", hsync_n, hs);
    chk(vsync_n == vs, "R5 vsync_n", vsync_n, vs);
    chk(de == dx, "R6/R7 de", de, dx);
    chk(raster_irq == iq, "R8 raster_irq", raster_irq, iq);
  endtask

  task automatic step();
    @(negedge clk);
    c++;
    if (c == frame_len()) begin
      c = 0;
      cur = pend;
    end
    check_all();
  endtask

  task automatic wr(input int sel, input int val);
    wr_en = 1'b1; wr_sel = 4'(sel); wr_data = V_W'(val);
    if (sel <= 8) pend[sel] = (sel == 0) ? (val | 1) : val; // R2 forced LSB, R9 select map
    step();
    wr_en = 1'b0;
  endtask

  task automatic to_wrap();
    do step(); while (c != 0);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) repeat (frame_len()) step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state seen while reset still held
    chk(dot_col == '0 && line == '0, "R10 reset counters", int'(dot_col), 0);
    rst_n = 1'b1;
    check_all();
    while (c < 20) step();
    // config B: HT written 14 -> 15 (R2), irq on active line 2 (R8)
    wr(0, 14); wr(1, 15); wr(2, 2); wr(3, 0); wr(4, 1); wr(5, 6);
    wr(6, 3); wr(7, 13); wr(8, 3 + 1 + 2);
    wr(12, 0); // R9 unused code ignored
    to_wrap();
    chk(cur[0] == 15, "R9 config B active", cur[0], 15);
    frames(2);
    while (c < 30) step();
    // config C: HT written 6 -> 7 (R2), irq on active line 1 (R8)
    wr(0, 6); wr(1, 5); wr(2, 0); wr(3, 2); wr(4, 0); wr(5, 1);
    wr(6, 1); wr(7, 4); wr(8, 1 + 1 + 1);
    wr(15, 1023); // R9 unused code ignored
    to_wrap();
    frames(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule